// File: doc/BRIEF.md
# Majority-Vote Repeated Read Filter

This block sits between a host read path and a register target whose reads cannot be trusted to return the same word every time. A host read is not forwarded once. The block reads the same downstream address many times in a row, one sample per clock. It tallies every distinct value it sees and returns the value that occurred most often.

The tally lives in a table with one value and one occurrence count per entry. A sample that matches an occupied entry raises that entry's count. A sample that matches nothing is placed in the lowest free entry with a count of one. Alongside the table the block tracks a leader: the entry whose count is highest. An entry takes the lead only by strictly exceeding the current leading count, so on a tie the entry that reached that count first keeps the lead.

The sampling window normally covers `NSAMP` reads. It is cut short on the cycle the leader's count passes half the window, because no other value can overtake it after that point. Stopping early also ends the downstream reads. The result appears with a one-cycle valid pulse. The table is emptied whenever a new request is accepted.

Top module: `mode_vote_reader`

## Requirements
- R1: While reset is asserted and right after it, `ready_o` is 1, `rsp_valid_o` is 0 and `dn_rd_o` is 0.
- R2: A request is accepted on a clock edge where `req_i` and `ready_o` are both 1. From the next cycle, `dn_rd_o` is 1 every cycle until the response, with `dn_addr_o` equal to the accepted address. `dn_rdata_i` is taken in the same cycle as each read strobe. `dn_rd_o` is 0 while the block is idle.
- R3: A request issues at most `NSAMP` (default 100) downstream reads. When no value ever exceeds half the window, exactly `NSAMP` reads are issued.
- R4: Sampling stops after the first read that takes one value's count above `NSAMP/2`, which is 51 with the defaults. No further read is issued for that request.
- R5: The returned data equals the most frequent sampled value.
- R6: When several values share the highest count, the value that reached that count first is returned.
- R7: The table has room for `NSAMP` distinct values. When every sample differs, the first sample is returned and all `NSAMP` reads are issued.
- R8: `rsp_valid_o` is a one-cycle pulse in the cycle after the last downstream read. `ready_o` is 0 from acceptance until that pulse. A request raised while busy is ignored and produces neither a second response nor an address change.
- R9: The table and the leader are cleared when a request is accepted, so results from earlier requests never affect a later one. This also holds after a reset in the middle of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host read request |
| req_addr_i | input | AW | Host read address |
| ready_o | output | 1 | Idle; a request is accepted when high |
| rsp_valid_o | output | 1 | One-cycle pulse with the voted result |
| rsp_data_o | output | DW | Voted read data |
| dn_rd_o | output | 1 | Downstream read strobe, one sample per cycle |
| dn_addr_o | output | AW | Downstream read address |
| dn_rdata_i | input | DW | Downstream read data, valid in the strobe cycle |

## Verification
The assertions assume that the downstream target returns its word combinationally in the same cycle as the strobe. They also assume the host treats `ready_o` as the only sign of acceptance, so a request seen while busy is simply dropped. The bench follows both rules. Its downstream model looks up the sample index, counted from each accepted request, in the strobe cycle. It raises `req_i` for exactly one cycle at an idle edge, except for a deliberate one-cycle request in the middle of a run, which checks that such a request is ignored. Every pattern is designed so that its winning value and read count can be worked out by hand.

// File: rtl/mode_vote_reader.sv
module mode_vote_reader #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int NSAMP = 100,
  parameter int NENT  = NSAMP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          ready_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          dn_rd_o,
  output logic [AW-1:0] dn_addr_o,
  input  logic [DW-1:0] dn_rdata_i
);

  localparam int CW = $clog2(NSAMP + 1);
  localparam int UW = $clog2(NENT + 1);
  localparam logic [CW-1:0] LAST_S = CW'(NSAMP - 1);
  localparam logic [CW-1:0] HALF_C = CW'(NSAMP / 2);
  localparam logic [UW-1:0] FULL_U = UW'(NENT);

  logic          busy_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] smp_q;
  logic [UW-1:0] used_q;
  logic [CW-1:0] lead_cnt_q;
  logic [DW-1:0] lead_val_q;

  logic [DW-1:0] ent_val [NENT];
  logic [CW-1:0] ent_cnt [NENT];

  logic [NENT-1:0] hit_vec, hit_first;
  logic            hit_any, tbl_full, store, take_lead, last;
  logic [CW-1:0]   hit_cnt, new_cnt;

  for (genvar j = 0; j < NENT; j++) begin : g_cmp
    assign hit_vec[j] = (UW'(j) < used_q) && (ent_val[j] == dn_rdata_i);
  end

  always_comb begin
    hit_first = '0;
    hit_any   = 1'b0;
    hit_cnt   = '0;
    for (int j = 0; j < NENT; j++) begin
      if (hit_vec[j] && !hit_any) begin
        hit_first[j] = 1'b1;
        hit_any      = 1'b1;
        hit_cnt      = ent_cnt[j];
      end
    end
  end

  assign tbl_full  = (used_q == FULL_U);
  assign store     = hit_any || !tbl_full;
  assign new_cnt   = hit_any ? hit_cnt + 1'b1 : CW'(1);
  assign take_lead = busy_q && store && (new_cnt > lead_cnt_q);
  assign last      = busy_q && ((smp_q == LAST_S) || (take_lead && new_cnt > HALF_C));

  for (genvar j = 0; j < NENT; j++) begin : g_ent
    always_ff @(posedge clk) begin
      if (busy_q && hit_first[j]) begin
        ent_cnt[j] <= ent_cnt[j] + 1'b1;
      end else if (busy_q && !hit_any && !tbl_full && used_q == UW'(j)) begin
        ent_val[j] <= dn_rdata_i;
        ent_cnt[j] <= CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      addr_q      <= '0;
      smp_q       <= '0;
      used_q      <= '0;
      lead_cnt_q  <= '0;
      lead_val_q  <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (!busy_q) begin
        if (req_i) begin
          busy_q     <= 1'b1;
          addr_q     <= req_addr_i;
          smp_q      <= '0;
          used_q     <= '0;
          lead_cnt_q <= '0;
          lead_val_q <= '0;
        end
      end else begin
        smp_q <= smp_q + 1'b1;
        if (!hit_any && !tbl_full) used_q <= used_q + 1'b1;
        if (take_lead) begin
          lead_cnt_q <= new_cnt;
          lead_val_q <= dn_rdata_i;
        end
        if (last) begin
          busy_q      <= 1'b0;
          rsp_valid_o <= 1'b1;
          rsp_data_o  <= take_lead ? dn_rdata_i : lead_val_q;
        end
      end
    end
  end

  assign ready_o   = !busy_q;
  assign dn_rd_o   = busy_q;
  assign dn_addr_o = addr_q;

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !dn_rd_o); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rd_o && $past(dn_rd_o)) |-> $stable(dn_addr_o)); // R2
  AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rd_o |-> (smp_q < CW'(NSAMP))); // R3
  AST_MAJORITY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rd_o |-> (lead_cnt_q <= HALF_C)); // R4
  AST_TABLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rd_o |-> (CW'(used_q) <= smp_q)); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o); // R8
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> ($past(dn_rd_o) && ready_o)); // R8

endmodule

// File: tb/mode_vote_reader_test.sv
module mode_vote_reader_test;
  localparam int PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  localparam logic [31:0] VA = 32'hA5A5_0001;
  localparam logic [31:0] VB = 32'h5A5A_0002;
  localparam logic [31:0] VC = 32'h0000_0C0C;

  localparam int NV = 8;
  localparam logic [31:0] EXP_VAL [NV] = '{VA, VA, VC, 32'h1000_0000, VA, VB, VA, VB};
  localparam int EXP_RD [NV] = '{51, 100, 54, 100, 100, 100, 100, 52};
  localparam int TAGK [NV] = '{0, 1, 0, 2, 0, 0, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic ready_o, rsp_valid_o, dn_rd_o;
  logic [DW-1:0] rsp_data_o, dn_rdata_i;
  logic [AW-1:0] dn_addr_o;

  int checks = 0;
  int errors = 0;
  int cur_pat = 0;
  int rd_idx = 0;
  int addr_bad = 0;
  logic [AW-1:0] exp_addr = '0;

  always #(PERIOD/2) clk = ~clk;

  mode_vote_reader uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_addr_i(req_addr_i),
    .ready_o(ready_o), .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .dn_rd_o(dn_rd_o), .dn_addr_o(dn_addr_o), .dn_rdata_i(dn_rdata_i)
  );

  function automatic logic [31:0] pat_val(int p, int i);
    case (p)
      0: pat_val = VA;
      1: pat_val = (i % 2 == 0) ? VA : VB;
      2: pat_val = (i < 3) ? 32'h2000_0000 + i : VC;
      3: pat_val = 32'h1000_0000 + i;
      4: pat_val = (i % 3 == 0) ? VA : ((i % 3 == 1) ? VB : VC);
      5: pat_val = (i < 49) ? VA : VB;
      6: pat_val = (i < 50) ? VA : VB;
      7: pat_val = (i == 0) ? 32'hDEAD_0000 : VB;
      default: pat_val = VB;
    endcase
  endfunction

  always_comb dn_rdata_i = pat_val(cur_pat, rd_idx);

  always @(posedge clk) begin
    if (req_i && ready_o) rd_idx <= 0;
    else if (dn_rd_o) rd_idx <= rd_idx + 1;
    if (dn_rd_o && dn_addr_o != exp_addr) addr_bad <= addr_bad + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [AW-1:0] a, input int p, input logic [31:0] ev,
                         input int er, input string dtag, input bit poke);
    int n;
    bit seen;
    @(negedge clk);
    cur_pat = p;
    exp_addr = a;
    req_addr_i = a;
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk(!ready_o && dn_rd_o, "R2 busy after accept", {30'd0, ready_o, dn_rd_o}, 32'd1);
    seen = 1'b0;
    n = 0;
    while (!seen && n < 300) begin
      if (poke && n == 10) begin
        req_addr_i = a ^ 16'hFFFF;
        req_i = 1'b1;
      end
      @(negedge clk);
      req_i = 1'b0;
      n++;
      seen = rsp_valid_o;
    end
    chk(seen, "R8 response timeout", 32'(n), 32'(er));
    chk(rsp_data_o == ev, dtag, rsp_data_o, ev);
    chk(rd_idx == er, "R3 R4 read count", 32'(rd_idx), 32'(er));
    chk(ready_o && !dn_rd_o, "R8 idle with response", {30'd0, ready_o, dn_rd_o}, 32'd2);
    @(negedge clk);
    chk(!rsp_valid_o, "R8 single pulse", {31'd0, rsp_valid_o}, 32'd0);
    chk(addr_bad == 0, "R2 downstream address", 32'(addr_bad), 32'd0);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string t;
    repeat (3) @(negedge clk);
    chk(ready_o && !rsp_valid_o && !dn_rd_o, "R1 reset state",
        {29'd0, ready_o, rsp_valid_o, dn_rd_o}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready_o && !rsp_valid_o && !dn_rd_o, "R1 after reset",
        {29'd0, ready_o, rsp_valid_o, dn_rd_o}, 32'd4);
    @(negedge clk);
    chk(!dn_rd_o, "R2 no read while idle", {31'd0, dn_rd_o}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      t = (TAGK[v] == 1) ? "R6 tie winner" : ((TAGK[v] == 2) ? "R7 distinct values" : "R5 mode value");
      run_req(16'(16'h0100 + v), v, EXP_VAL[v], EXP_RD[v], t, 1'b0);
    end

    run_req(16'h0A00, 0, VA, 51, "R9 first of pair", 1'b0);
    run_req(16'h0A04, 8, VB, 51, "R9 table cleared", 1'b0);

    run_req(16'h0B00, 4, VA, 100, "R8 busy request ignored", 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk(!rsp_valid_o && !dn_rd_o, "R8 no second response",
          {30'd0, rsp_valid_o, dn_rd_o}, 32'd0);
    end

    @(negedge clk);
    cur_pat = 0;
    exp_addr = 16'h0C00;
    req_addr_i = 16'h0C00;
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ready_o && !rsp_valid_o && !dn_rd_o, "R1 reset mid request",
        {29'd0, ready_o, rsp_valid_o, dn_rd_o}, 32'd4);
    rst_n = 1'b1;
    run_req(16'h0C08, 5, VB, 100, "R9 clean after reset", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule